// File: doc/BRIEF.md
# Selective-Flush Translation Cache

This block is a small, fully associative cache of address translations for one hardware thread. Each slot holds a virtual page number, an address-space identifier, a global flag, a physical page number and a set of permission bits. A lookup presents a page number and the current address-space identifier. One cycle later the block answers with hit or miss and, on a hit, the physical page and the permissions. A refill port writes a new translation that a page walker outside the block has produced. Refill picks the slot itself: the lowest free slot if there is one, otherwise a round-robin pointer.

The invalidate port carries a page number with a "page given" flag and an identifier with an "identifier given" flag. The two flags select one of four scopes. Global translations are kept by the scopes that name an identifier. They are removed by the page-only scope and by the flush-everything scope. The same port serves both the ordering fence and the fine-grained invalidate: for equal operands both must remove exactly the same set of slots, so one shared path implements both.

Within one cycle the order is fixed. The invalidate is applied first. A lookup in that same cycle compares against the state after the invalidate. The refill is written last, so a lookup in the same cycle does not see it.

Top module: `tlb_sel_flush`

## Requirements
- R1: After reset every slot is invalid, so any lookup misses.
- R2: A lookup issued in cycle N is answered in cycle N+1: rsp_valid is high exactly in the cycle after lk_valid. It hits only when a valid slot has the same page number and either carries the lookup identifier or has its global flag set. On a hit the slot's ppn and perm are returned. On a miss rsp_ppn and rsp_perm are zero.
- R3: When several slots hit, the slot with the lowest index supplies the response.
- R4: Invalidate with inv_use_va=1 and inv_use_asid=1 removes valid, non-global slots whose page and identifier both match.
- R5: Invalidate with inv_use_va=1 and inv_use_asid=0 removes every slot whose page matches, whatever its identifier, global slots included.
- R6: Invalidate with inv_use_va=0 and inv_use_asid=1 removes every non-global slot carrying that identifier; global slots stay.
- R7: Invalidate with both flags 0 removes every slot.
- R8: A lookup in the same cycle as an invalidate sees the state after the invalidate. A refill in that cycle is not visible to it.
- R9: Refill writes the lowest-index slot that is free after the same cycle's invalidate. If none is free, it writes the slot under the round-robin pointer. The pointer is 0 after reset, advances by one (wrapping at ENTRIES-1) only when it is used, and is never moved by freeing slots.
- R10: When refill and invalidate happen in the same cycle, the invalidate is applied first and the refilled slot survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill identifier |
| rf_global | input | 1 | Refill global flag |
| rf_ppn | input | PPN_W | Refill physical page |
| rf_perm | input | PERM_W | Refill permission bits |
| inv_valid | input | 1 | Invalidate command |
| inv_use_va | input | 1 | Page operand given |
| inv_vpn | input | VPN_W | Page operand |
| inv_use_asid | input | 1 | Identifier operand given |
| inv_asid | input | ASID_W | Identifier operand |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Translated physical page (0 on miss) |
| rsp_perm | output | PERM_W | Permission bits (0 on miss) |

## Verification
The only view into the slots is a lookup, so a corrupt valid bit, tag or global flag shows up as a wrong hit or a wrong miss. It appears one cycle after the first lookup that touches the affected page. A wrong replacement choice stays hidden until the evicted translation is looked up, or until a later refill lands in an unexpected slot. For that reason the stimulus uses a small page and identifier space, which fills the cache and forces frequent reuse. A bench reference model mirrors the slot contents and the round-robin pointer, so every response checks the whole history of refills and invalidates.

// File: rtl/tlb_sel_pkg.sv
package tlb_sel_pkg;

    // Scope encoding: bit 1 = page operand given, bit 0 = identifier operand given.
    typedef enum logic [1:0] {
        SCOPE_ALL       = 2'b00,
        SCOPE_ASID      = 2'b01,
        SCOPE_PAGE      = 2'b10,
        SCOPE_PAGE_ASID = 2'b11
    } inv_scope_e;

    function automatic inv_scope_e scope_of(input logic use_va, input logic use_asid);
        return inv_scope_e'({use_va, use_asid});
    endfunction

endpackage

// File: rtl/tlb_inv_match.sv
module tlb_inv_match
    import tlb_sel_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 9
) (
    input  logic                           inv_valid,
    input  logic                           inv_use_va,
    input  logic [VPN_W-1:0]               inv_vpn,
    input  logic                           inv_use_asid,
    input  logic [ASID_W-1:0]              inv_asid,
    input  logic [ENTRIES-1:0]             ent_vld,
    input  logic [ENTRIES-1:0]             ent_glb,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    output logic [ENTRIES-1:0]             kill
);
    inv_scope_e scope;
    assign scope = scope_of(inv_use_va, inv_use_asid);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic page_eq;
        logic asid_eq;
        assign page_eq = (ent_vpn[g] == inv_vpn);
        assign asid_eq = (ent_asid[g] == inv_asid);
        always_comb begin
            unique case (scope)
                SCOPE_PAGE_ASID: kill[g] = page_eq && asid_eq && !ent_glb[g];
                SCOPE_PAGE:      kill[g] = page_eq;
                SCOPE_ASID:      kill[g] = asid_eq && !ent_glb[g];
                default:         kill[g] = 1'b1;
            endcase
            kill[g] = kill[g] && inv_valid && ent_vld[g];
        end
    end
endmodule

// File: rtl/tlb_lookup_match.sv
module tlb_lookup_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 9
) (
    input  logic [VPN_W-1:0]               req_vpn,
    input  logic [ASID_W-1:0]              req_asid,
    input  logic [ENTRIES-1:0]             ent_vld,
    input  logic [ENTRIES-1:0]             ent_glb,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    output logic [ENTRIES-1:0]             hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_vpn[g] == req_vpn) &&
                            (ent_glb[g] || (ent_asid[g] == req_asid));
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] occupied,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               take_rr
);
    always_comb begin
        take_rr = &occupied;
        victim  = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occupied[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_sel_flush.sv
module tlb_sel_flush #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 9,
    parameter int PPN_W   = 22,
    parameter int PERM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic              rf_global,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              inv_valid,
    input  logic              inv_use_va,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              inv_use_asid,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] tbl;
        logic [IDX_W-1:0]    rr;
        logic                rsp_vld;
        logic                rsp_hit;
        logic [PPN_W-1:0]    rsp_ppn;
        logic [PERM_W-1:0]   rsp_perm;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]             vld_q_v, glb_q_v, post_vld_v, kill_v, hit_v;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q_v;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q_v;
    logic [IDX_W-1:0]               victim;
    logic                           take_rr;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_q_v[i]  = st_q.tbl[i].vld;
            glb_q_v[i]  = st_q.tbl[i].glb;
            vpn_q_v[i]  = st_q.tbl[i].vpn;
            asid_q_v[i] = st_q.tbl[i].asid;
        end
    end

    tlb_inv_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_inv (
        .inv_valid    (inv_valid),
        .inv_use_va   (inv_use_va),
        .inv_vpn      (inv_vpn),
        .inv_use_asid (inv_use_asid),
        .inv_asid     (inv_asid),
        .ent_vld      (vld_q_v),
        .ent_glb      (glb_q_v),
        .ent_vpn      (vpn_q_v),
        .ent_asid     (asid_q_v),
        .kill         (kill_v)
    );

    assign post_vld_v = vld_q_v & ~kill_v;

    tlb_lookup_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lkup (
        .req_vpn  (lk_vpn),
        .req_asid (lk_asid),
        .ent_vld  (post_vld_v),
        .ent_glb  (glb_q_v),
        .ent_vpn  (vpn_q_v),
        .ent_asid (asid_q_v),
        .hit_vec  (hit_v)
    );

    tlb_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
        .occupied (post_vld_v),
        .rr_ptr   (st_q.rr),
        .victim   (victim),
        .take_rr  (take_rr)
    );

    always_comb begin
        logic [IDX_W-1:0] sel;
        st_d = st_q;
        // invalidate first
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.tbl[i].vld = post_vld_v[i];
        end
        // lookup against post-invalidate state, lowest index wins
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_v[i]) sel = IDX_W'(i);
        end
        st_d.rsp_vld  = lk_valid;
        st_d.rsp_hit  = lk_valid && (|hit_v);
        st_d.rsp_ppn  = st_d.rsp_hit ? st_q.tbl[sel].ppn  : '0;
        st_d.rsp_perm = st_d.rsp_hit ? st_q.tbl[sel].perm : '0;
        // refill last
        if (rf_valid) begin
            st_d.tbl[victim] = '{vld: 1'b1, glb: rf_global, asid: rf_asid,
                                 vpn: rf_vpn, ppn: rf_ppn, perm: rf_perm};
            if (take_rr) begin
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_vld;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_ppn   = st_q.rsp_ppn;
    assign rsp_perm  = st_q.rsp_perm;

    // R2: answer exactly one cycle after the request
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R2: miss returns zeros
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0));
    // R7: flush-everything leaves nothing valid
    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_use_va && !inv_use_asid && !rf_valid) |=> (vld_q_v == '0));
    // R8: lookup in the cycle of a full flush cannot hit
    p_lookup_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_use_va && !inv_use_asid && lk_valid) |=> !rsp_hit);
    // R9: refill into a non-full cache grows occupancy by one
    p_refill_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !inv_valid && !(&vld_q_v)) |=>
        ($countones(vld_q_v) == $past($countones(vld_q_v)) + 1));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R6: identifier-scoped flush keeps global slots
        p_global_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_valid && !inv_use_va && inv_use_asid && !rf_valid &&
             vld_q_v[g] && glb_q_v[g]) |=> vld_q_v[g]);
    end
endmodule

// File: tb/test_tlb_sel_flush.sv
module test_tlb_sel_flush;
    localparam int CLK_P   = 10;
    localparam int N       = 8;
    localparam int VPN_W   = 20;
    localparam int ASID_W  = 9;
    localparam int PPN_W   = 22;
    localparam int PERM_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, rf_valid = 0, rf_global = 0, inv_valid = 0, inv_use_va = 0, inv_use_asid = 0;
    logic [VPN_W-1:0]  lk_vpn = '0, rf_vpn = '0, inv_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0, rf_asid = '0, inv_asid = '0;
    logic [PPN_W-1:0]  rf_ppn = '0;
    logic [PERM_W-1:0] rf_perm = '0;
    logic rsp_valid, rsp_hit;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [PERM_W-1:0] rsp_perm;

    always #(CLK_P/2) clk = ~clk;

    tlb_sel_flush #(.ENTRIES(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W), .PERM_W(PERM_W))
    i_tlb_sel_flush (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model
    bit                m_vld [N];
    bit                m_glb [N];
    logic [VPN_W-1:0]  m_vpn [N];
    logic [ASID_W-1:0] m_asid[N];
    logic [PPN_W-1:0]  m_ppn [N];
    logic [PERM_W-1:0] m_perm[N];
    int                m_rr;

    function automatic bit kill_of(int i, bit iva, logic [VPN_W-1:0] iv, bit ias, logic [ASID_W-1:0] ia);
        if (!m_vld[i]) return 0;
        if (iva && ias) return (m_vpn[i] == iv) && (m_asid[i] == ia) && !m_glb[i];
        if (iva)        return (m_vpn[i] == iv);
        if (ias)        return (m_asid[i] == ia) && !m_glb[i];
        return 1;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag,
                        bit lk, logic [VPN_W-1:0] lv, logic [ASID_W-1:0] la,
                        bit rf, logic [VPN_W-1:0] rv, logic [ASID_W-1:0] ra, bit rg,
                        logic [PPN_W-1:0] rp, logic [PERM_W-1:0] rperm,
                        bit inv, bit iva, logic [VPN_W-1:0] iv, bit ias, logic [ASID_W-1:0] ia);
        bit e_hit;
        logic [PPN_W-1:0] e_ppn;
        logic [PERM_W-1:0] e_perm;
        int vic;
        lk_valid = lk; lk_vpn = lv; lk_asid = la;
        rf_valid = rf; rf_vpn = rv; rf_asid = ra; rf_global = rg; rf_ppn = rp; rf_perm = rperm;
        inv_valid = inv; inv_use_va = iva; inv_vpn = iv; inv_use_asid = ias; inv_asid = ia;
        @(posedge clk);
        if (inv) for (int i = 0; i < N; i++) if (kill_of(i, iva, iv, ias, ia)) m_vld[i] = 0;
        e_hit = 0; e_ppn = '0; e_perm = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_vld[i] && m_vpn[i] == lv && (m_glb[i] || m_asid[i] == la)) begin
                e_hit = lk; e_ppn = lk ? m_ppn[i] : '0; e_perm = lk ? m_perm[i] : '0;
            end
        if (rf) begin
            vic = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) vic = i;
            if (vic < 0) begin vic = m_rr; m_rr = (m_rr == N - 1) ? 0 : m_rr + 1; end
            m_vld[vic] = 1; m_glb[vic] = rg; m_vpn[vic] = rv; m_asid[vic] = ra;
            m_ppn[vic] = rp; m_perm[vic] = rperm;
        end
        @(negedge clk);
        lk_valid = 0; rf_valid = 0; inv_valid = 0;
        check(tag, "rsp_valid", 32'(rsp_valid), 32'(lk));
        if (lk) begin
            check(tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
            check(tag, "rsp_ppn", 32'(rsp_ppn), 32'(e_ppn));
            check(tag, "rsp_perm", 32'(rsp_perm), 32'(e_perm));
        end
    endtask

    task automatic look(string tag, logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
        step(tag, 1, v, a, 0, '0, '0, 0, '0, '0, 0, 0, '0, 0, '0);
    endtask
    task automatic fill(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a, bit g, logic [PPN_W-1:0] p);
        step("R9", 0, '0, '0, 1, v, a, g, p, PERM_W'(p), 0, 0, '0, 0, '0);
    endtask
    task automatic flush(string tag, bit iva, logic [VPN_W-1:0] v, bit ias, logic [ASID_W-1:0] a);
        step(tag, 0, '0, '0, 0, '0, '0, 0, '0, '0, 1, iva, v, ias, a);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_glb[i] = 0; m_vpn[i] = '0;
            m_asid[i] = '0; m_ppn[i] = '0; m_perm[i] = '0; end
        m_rr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        look("R1", 20'h0, 9'h0);
        look("R1", 20'h5, 9'h1);
        // R2 basic hits, global match across identifiers
        fill(20'h1, 9'h1, 0, 22'h111);
        fill(20'h2, 9'h2, 1, 22'h222);
        fill(20'h1, 9'h2, 0, 22'h333);
        look("R2", 20'h1, 9'h1);
        look("R2", 20'h2, 9'h5);
        look("R2", 20'h1, 9'h2);
        look("R2", 20'h1, 9'h3);
        // R3 duplicates: lowest index wins
        fill(20'h3, 9'h1, 0, 22'h0AA);
        fill(20'h3, 9'h1, 0, 22'h0BB);
        look("R3", 20'h3, 9'h1);
        // R4 page+id keeps global and other identifiers
        fill(20'h2, 9'h1, 0, 22'h444);
        flush("R4", 1, 20'h2, 1, 9'h2);
        look("R4", 20'h2, 9'h2);
        flush("R4", 1, 20'h1, 1, 9'h1);
        look("R4", 20'h1, 9'h1);
        look("R4", 20'h1, 9'h2);
        // R6 identifier scope keeps global
        flush("R6", 0, '0, 1, 9'h2);
        look("R6", 20'h2, 9'h2);
        look("R6", 20'h1, 9'h2);
        // R5 page scope removes global too
        flush("R5", 1, 20'h2, 0, '0);
        look("R5", 20'h2, 9'h7);
        // R9 fill up and wrap round-robin
        for (int k = 0; k < N + 3; k++) fill(VPN_W'(16 + k), 9'h4, 0, PPN_W'(22'h500 + k));
        for (int k = 0; k < N + 3; k++) look("R9", VPN_W'(16 + k), 9'h4);
        // R8 + R10: flush all, same-cycle lookup and refill
        step("R8", 1, 20'h3, 9'h1, 1, 20'h9, 9'h1, 0, 22'h999, 4'h9, 1, 0, '0, 0, '0);
        look("R10", 20'h9, 9'h1);
        look("R7", 20'h3, 9'h1);
        flush("R7", 0, '0, 0, '0);
        look("R7", 20'h9, 9'h1);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            bit lk, rf, inv;
            lk  = ($urandom % 10) < 7;
            rf  = ($urandom % 10) < 3;
            inv = ($urandom % 10) < 1;
            step("R2", lk, VPN_W'($urandom % 12), ASID_W'($urandom % 4),
                 rf, VPN_W'($urandom % 12), ASID_W'($urandom % 4), ($urandom % 5) == 0,
                 PPN_W'($urandom), PERM_W'($urandom),
                 inv, $urandom % 2 == 1, VPN_W'($urandom % 12), $urandom % 2 == 1, ASID_W'($urandom % 4));
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule